// File: doc/BRIEF.md
# Frame-aligning justification demultiplexer

This block receives one high-speed NRZ bit per clock cycle and recovers four lower-rate tributaries from it. It hunts for a 10-bit alignment word, sliding one bit at a time, and confirms the frame phase over several frames before it declares lock. It keeps that lock through short error bursts. Once locked, it steers every payload bit to its tributary, resolves each tributary's justification opportunity by majority vote over three control bits, and emits the tributary data with a gapped clock strobe.

The `mode` input picks between a short frame of 848 bits and a long frame of 1536 bits. Both formats share one layout rule: the frame is four equal sets of S = frame/4 bits (212 or 384), and 28 overhead bits are placed at fixed offsets. The received alarm bit, national bit and justification opportunity bits are held on status outputs, refreshed once per locked frame. Line decoding and smoothing of the gapped clocks belong to neighbouring blocks.

Top module: `edmx_demux`

## Requirements
- R1: The search compares the last ten received bits, oldest first, with 1111010000 on every cycle. A match fixes the frame phase, with the matching bit as set 0 offset 9. `locked` rises in the cycle after the word is seen again at that phase in each of the next two frames, three sightings in all.
- R2: While locked, a wrong alignment word in three consecutive frames keeps `locked` high. A fourth consecutive wrong word drops `locked` in the cycle after its offset-9 bit and restarts the search. A correct word clears the miss count.
- R3: During confirmation, a wrong word at the expected phase returns the block to the search without declaring lock.
- R4: While `locked` is low, all `trib_clk` bits stay 0, and `rx_alarm`, `rx_national` and `rx_jflags` keep their values.
- R5: Frame layout for set k and offset o. In set 0, offsets 0-9 carry the word, offset 10 the alarm bit and offset 11 the national bit. In sets 1 to 3, offsets 0-3 carry the control bits of tributaries 0 to 3. In set 3, offsets 4-7 carry the justification opportunity bits of tributaries 0 to 3. Every other bit is data for tributary o mod 4.
- R6: A justification opportunity bit counts as stuffing when at least two of its tributary's three control bits (one each in sets 1, 2 and 3) are 1. A stuffing bit gets no clock pulse. Otherwise the bit is delivered as data.
- R7: A delivered bit produces a one-cycle pulse on `trib_clk[t]`, with the bit on `trib_data[t]`, in the cycle after it was received. Bits keep their order. `trib_data[t]` holds between pulses, and at most one tributary pulses in any cycle.
- R8: With `mode` low, each locked frame delivers 205 data bits per tributary, plus the opportunity bit when it is not stuffing.
- R9: The alarm and national bits of each locked frame are latched onto `rx_alarm` and `rx_national` and held.
- R10: The four opportunity bits of each locked frame are latched onto `rx_jflags` (bit t for tributary t), whether or not they are stuffing.
- R11: With `mode` high, the frame is 1536 bits (S = 384), and each locked frame delivers 377 data bits per tributary, plus the non-stuffing opportunity bit.
- R12: While reset is asserted (`rst_n` low), `locked`, `trib_clk`, `trib_data`, `rx_alarm`, `rx_national` and `rx_jflags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock of the high-speed stream |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | Frame format: 0 = 848 bits, 1 = 1536 bits |
| din | input | 1 | Incoming NRZ bit, one per cycle |
| locked | output | 1 | Frame alignment achieved |
| trib_clk | output | 4 | Gapped clock strobe per tributary |
| trib_data | output | 4 | NRZ data per tributary |
| rx_alarm | output | 1 | Alarm bit of the last locked frame |
| rx_national | output | 1 | National bit of the last locked frame |
| rx_jflags | output | 4 | Opportunity bits of the last locked frame |

## Verification
The checker watches several rules on every cycle. The strobes are silent and the status is frozen while out of lock. At most one tributary strobes in a cycle, and no tributary strobes twice in a row. `locked` changes only in the cycle after an alignment-word position.

Only the bench's frame scenarios can show the rest. That covers the three-sighting confirmation and the four-miss loss rule, the recovery after a failed confirmation, and the majority decision on stuffing. It also covers the exact number and order of delivered bits per tributary in both formats, and the latching of alarm, national and opportunity bits.

// File: rtl/edmx_pkg.sv
package edmx_pkg;

    localparam int NUM_TRIB   = 4;
    localparam int TSEL_W     = $clog2(NUM_TRIB);
    localparam int SET_W      = 2;
    localparam int AW_LEN     = 10;
    localparam logic [AW_LEN-1:0] ALIGN_WORD = 10'b1111010000;
    localparam int ALARM_OFF  = 10;
    localparam int NAT_OFF    = 11;
    localparam int CTL_LEN    = 4;
    localparam int JO_END     = 8;
    localparam int VOTE_MIN   = 2;

    typedef enum logic [1:0] {
        AL_SEARCH  = 2'd0,
        AL_CONFIRM = 2'd1,
        AL_LOCKED  = 2'd2
    } align_state_e;

    typedef enum logic [2:0] {
        BK_WORD  = 3'd0,
        BK_ALARM = 3'd1,
        BK_NAT   = 3'd2,
        BK_CTL   = 3'd3,
        BK_JO    = 3'd4,
        BK_DATA  = 3'd5
    } bit_kind_e;

endpackage

// File: rtl/edmx_frame_pos.sv
module edmx_frame_pos
    import edmx_pkg::*;
#(
    parameter int SET_LEN_LO = 212,
    parameter int SET_LEN_HI = 384,
    parameter int OFF_W      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,
    input  logic              resync,
    output logic              word_end,
    output bit_kind_e         kind,
    output logic [TSEL_W-1:0] trib_sel
);

    typedef struct packed {
        logic [SET_W-1:0] set;
        logic [OFF_W-1:0] off;
    } pos_t;

    pos_t             pos_q;
    pos_t             pos_d;
    logic [OFF_W-1:0] last_off;

    always_comb begin
        last_off = mode ? OFF_W'(SET_LEN_HI - 1) : OFF_W'(SET_LEN_LO - 1);
        pos_d    = pos_q;
        if (resync) begin
            // the bit just seen closes the word, the next one is offset 10
            pos_d.set = '0;
            pos_d.off = OFF_W'(AW_LEN);
        end else if (pos_q.off >= last_off) begin
            pos_d.off = '0;
            pos_d.set = pos_q.set + 1'b1;
        end else begin
            pos_d.off = pos_q.off + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    always_comb begin
        kind = BK_DATA;
        if (pos_q.set == '0) begin
            if (pos_q.off < OFF_W'(AW_LEN)) begin
                kind = BK_WORD;
            end else if (pos_q.off == OFF_W'(ALARM_OFF)) begin
                kind = BK_ALARM;
            end else if (pos_q.off == OFF_W'(NAT_OFF)) begin
                kind = BK_NAT;
            end
        end else if (pos_q.off < OFF_W'(CTL_LEN)) begin
            kind = BK_CTL;
        end else if ((pos_q.set == '1) && (pos_q.off < OFF_W'(JO_END))) begin
            kind = BK_JO;
        end
    end

    assign word_end = (pos_q.set == '0) && (pos_q.off == OFF_W'(AW_LEN - 1));
    assign trib_sel = pos_q.off[TSEL_W-1:0];

endmodule

// File: rtl/edmx_align.sv
module edmx_align
    import edmx_pkg::*;
#(
    parameter int CONFIRM_FRAMES = 3,
    parameter int LOSS_FRAMES    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic word_end,
    output logic locked,
    output logic resync
);

    localparam int CNT_MAX = (CONFIRM_FRAMES > LOSS_FRAMES) ? CONFIRM_FRAMES : LOSS_FRAMES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] CONF_LAST = CNT_W'(CONFIRM_FRAMES - 1);
    localparam logic [CNT_W-1:0] LOSS_LAST = CNT_W'(LOSS_FRAMES - 1);

    typedef struct packed {
        align_state_e      st;
        logic [AW_LEN-1:0] sr;
        logic [CNT_W-1:0]  cnt;
    } align_t;

    align_t            al_q;
    align_t            al_d;
    logic [AW_LEN-1:0] sr_next;
    logic              hit;

    always_comb begin
        sr_next = {al_q.sr[AW_LEN-2:0], din};
        hit     = (sr_next == ALIGN_WORD);
        al_d    = al_q;
        al_d.sr = sr_next;
        resync  = 1'b0;
        case (al_q.st)
            AL_SEARCH: begin
                if (hit) begin
                    resync    = 1'b1;
                    al_d.st   = AL_CONFIRM;
                    al_d.cnt  = CNT_W'(1);
                end
            end
            AL_CONFIRM: begin
                if (word_end) begin
                    if (!hit) begin
                        al_d.st  = AL_SEARCH;
                        al_d.cnt = '0;
                    end else if (al_q.cnt >= CONF_LAST) begin
                        al_d.st  = AL_LOCKED;
                        al_d.cnt = '0;
                    end else begin
                        al_d.cnt = al_q.cnt + 1'b1;
                    end
                end
            end
            AL_LOCKED: begin
                if (word_end) begin
                    if (hit) begin
                        al_d.cnt = '0;
                    end else if (al_q.cnt >= LOSS_LAST) begin
                        al_d.st  = AL_SEARCH;
                        al_d.cnt = '0;
                    end else begin
                        al_d.cnt = al_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                al_d.st  = AL_SEARCH;
                al_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            al_q <= '{st: AL_SEARCH, sr: '0, cnt: '0};
        end else begin
            al_q <= al_d;
        end
    end

    assign locked = (al_q.st == AL_LOCKED);

endmodule

// File: rtl/edmx_trib_route.sv
module edmx_trib_route
    import edmx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                din,
    input  logic                locked,
    input  bit_kind_e           kind,
    input  logic [TSEL_W-1:0]   trib_sel,
    output logic [NUM_TRIB-1:0] trib_clk,
    output logic [NUM_TRIB-1:0] trib_data,
    output logic                rx_alarm,
    output logic                rx_national,
    output logic [NUM_TRIB-1:0] rx_jflags
);

    typedef struct packed {
        logic [NUM_TRIB-1:0][1:0] votes;
        logic [NUM_TRIB-1:0]      tclk;
        logic [NUM_TRIB-1:0]      tdat;
        logic                     alarm;
        logic                     nat;
        logic [NUM_TRIB-1:0]      jflags;
    } route_t;

    route_t rt_q;
    route_t rt_d;

    always_comb begin
        rt_d      = rt_q;
        rt_d.tclk = '0;
        case (kind)
            BK_WORD: begin
                rt_d.votes = '0;
            end
            BK_ALARM: begin
                if (locked) rt_d.alarm = din;
            end
            BK_NAT: begin
                if (locked) rt_d.nat = din;
            end
            BK_CTL: begin
                for (int t = 0; t < NUM_TRIB; t++) begin
                    if ((trib_sel == TSEL_W'(t)) && din && (rt_q.votes[t] != 2'd3)) begin
                        rt_d.votes[t] = rt_q.votes[t] + 2'd1;
                    end
                end
            end
            BK_JO: begin
                for (int t = 0; t < NUM_TRIB; t++) begin
                    if ((trib_sel == TSEL_W'(t)) && locked) begin
                        rt_d.jflags[t] = din;
                        if (rt_q.votes[t] < 2'(VOTE_MIN)) begin
                            rt_d.tclk[t] = 1'b1;
                            rt_d.tdat[t] = din;
                        end
                    end
                end
            end
            default: begin
                for (int t = 0; t < NUM_TRIB; t++) begin
                    if ((trib_sel == TSEL_W'(t)) && locked) begin
                        rt_d.tclk[t] = 1'b1;
                        rt_d.tdat[t] = din;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_q <= '0;
        end else begin
            rt_q <= rt_d;
        end
    end

    assign trib_clk    = rt_q.tclk;
    assign trib_data   = rt_q.tdat;
    assign rx_alarm    = rt_q.alarm;
    assign rx_national = rt_q.nat;
    assign rx_jflags   = rt_q.jflags;

endmodule

// File: rtl/edmx_demux.sv
module edmx_demux
    import edmx_pkg::*;
#(
    parameter int SET_LEN_LO     = 212,
    parameter int SET_LEN_HI     = 384,
    parameter int CONFIRM_FRAMES = 3,
    parameter int LOSS_FRAMES    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode,
    input  logic                din,
    output logic                locked,
    output logic [NUM_TRIB-1:0] trib_clk,
    output logic [NUM_TRIB-1:0] trib_data,
    output logic                rx_alarm,
    output logic                rx_national,
    output logic [NUM_TRIB-1:0] rx_jflags
);

    localparam int SET_MAX = (SET_LEN_HI > SET_LEN_LO) ? SET_LEN_HI : SET_LEN_LO;
    localparam int OFF_W   = $clog2(SET_MAX);

    logic              resync_w;
    logic              word_end_w;
    logic              locked_w;
    bit_kind_e         kind_w;
    logic [TSEL_W-1:0] tsel_w;

    edmx_frame_pos #(
        .SET_LEN_LO (SET_LEN_LO),
        .SET_LEN_HI (SET_LEN_HI),
        .OFF_W      (OFF_W)
    ) pos_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .resync   (resync_w),
        .word_end (word_end_w),
        .kind     (kind_w),
        .trib_sel (tsel_w)
    );

    edmx_align #(
        .CONFIRM_FRAMES (CONFIRM_FRAMES),
        .LOSS_FRAMES    (LOSS_FRAMES)
    ) align_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .word_end (word_end_w),
        .locked   (locked_w),
        .resync   (resync_w)
    );

    edmx_trib_route route_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .din         (din),
        .locked      (locked_w),
        .kind        (kind_w),
        .trib_sel    (tsel_w),
        .trib_clk    (trib_clk),
        .trib_data   (trib_data),
        .rx_alarm    (rx_alarm),
        .rx_national (rx_national),
        .rx_jflags   (rx_jflags)
    );

    assign locked = locked_w;

endmodule

// File: rtl/edmx_demux_chk.sv
module edmx_demux_chk
    import edmx_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                locked,
    input logic [NUM_TRIB-1:0] trib_clk,
    input logic                rx_alarm,
    input logic                rx_national,
    input logic [NUM_TRIB-1:0] rx_jflags,
    input logic                word_end
);

    // R4: no strobe while out of lock
    a_r4_idle_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (trib_clk == '0));

    // R4: status frozen while out of lock
    a_r4_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> ($stable(rx_alarm) && $stable(rx_national) && $stable(rx_jflags)));

    // R7: one tributary per cycle at most
    a_r7_one_trib: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trib_clk));

    // R7: no tributary strobes in two consecutive cycles
    a_r7_gapped: assert property (@(posedge clk) disable iff (!rst_n)
        |trib_clk |=> ((trib_clk & $past(trib_clk)) == '0));

    // R1: lock is declared only right after an alignment-word position
    a_r1_lock_at_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(word_end));

    // R2: lock is dropped only right after an alignment-word position
    a_r2_loss_at_word: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(word_end));

endmodule

bind edmx_demux edmx_demux_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .locked      (locked),
    .trib_clk    (trib_clk),
    .rx_alarm    (rx_alarm),
    .rx_national (rx_national),
    .rx_jflags   (rx_jflags),
    .word_end    (word_end_w)
);

// File: tb/edmx_demux_tb_top.sv
module edmx_demux_tb_top;

    localparam logic [9:0] WORD   = 10'b1111010000;
    localparam int         S_LO   = 212;
    localparam int         S_HI   = 384;
    localparam int         NVEC   = 6;

    typedef struct packed {
        logic [11:0] ctl;    // bit t*3+k-1 : control bit of tributary t in set k
        logic [3:0]  jo;     // bit t : opportunity bit of tributary t
        logic        alarm;
        logic        nat;
        logic [3:0]  stuff;  // expected stuffing decision per tributary
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{ctl: 12'b000_000_000_000, jo: 4'b1010, alarm: 1'b0, nat: 1'b1, stuff: 4'b0000},
        '{ctl: 12'b111_111_111_111, jo: 4'b0101, alarm: 1'b1, nat: 1'b0, stuff: 4'b1111},
        '{ctl: 12'b001_101_100_011, jo: 4'b1100, alarm: 1'b0, nat: 1'b0, stuff: 4'b0101},
        '{ctl: 12'b111_000_010_110, jo: 4'b0011, alarm: 1'b1, nat: 1'b1, stuff: 4'b1001},
        '{ctl: 12'b011_110_101_001, jo: 4'b1111, alarm: 1'b1, nat: 1'b0, stuff: 4'b1110},
        '{ctl: 12'b000_000_000_000, jo: 4'b0000, alarm: 1'b0, nat: 1'b0, stuff: 4'b0000}
    };
    localparam vec_t VSAFE = '{ctl: 12'hFFF, jo: 4'hF, alarm: 1'b1, nat: 1'b1, stuff: 4'hF};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0;
    logic       din = 1'b0;
    logic       locked;
    logic [3:0] trib_clk;
    logic [3:0] trib_data;
    logic       rx_alarm;
    logic       rx_national;
    logic [3:0] rx_jflags;

    always #5 clk = ~clk;

    edmx_demux dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .din         (din),
        .locked      (locked),
        .trib_clk    (trib_clk),
        .trib_data   (trib_data),
        .rx_alarm    (rx_alarm),
        .rx_national (rx_national),
        .rx_jflags   (rx_jflags)
    );

    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;
    bit         exp_q [4][$];
    int         pulse_cnt [4];
    int         data_err = 0;
    logic       mon_e;
    logic [15:0] lfsr = 16'hACE1;
    logic [9:0] hist = '0;

    bit         pend_valid = 1'b0;
    int         pend_cnt [4];
    bit         pend_locked = 1'b0;
    string      pend_tag = "";
    logic       exp_alarm = 1'b0;
    logic       exp_nat = 1'b0;
    logic [3:0] exp_jf = '0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        for (int t = 0; t < 4; t++) begin
            if (trib_clk[t]) begin
                pulse_cnt[t]++;
                if (exp_q[t].size() == 0) begin
                    data_err++;
                end else begin
                    mon_e = exp_q[t].pop_front();
                    if (mon_e !== trib_data[t]) data_err++;
                end
            end
        end
    end

    task automatic send(input logic b);
        @(posedge clk);
        #2;
        din  = b;
        hist = {hist[8:0], b};
    endtask

    task automatic do_check();
        for (int t = 0; t < 4; t++) begin
            chk(pend_tag, $sformatf("pulses on tributary %0d", t), pulse_cnt[t], pend_cnt[t]);
            chk(pend_tag, $sformatf("undelivered bits tributary %0d", t), exp_q[t].size(), 0);
            pulse_cnt[t] = 0;
        end
        chk(pend_tag, "data order/value errors", data_err, 0);
        data_err = 0;
        chk(pend_tag, "locked", int'(locked), int'(pend_locked));
        chk(pend_tag, "rx_alarm (R9)", int'(rx_alarm), int'(exp_alarm));
        chk(pend_tag, "rx_national (R9)", int'(rx_national), int'(exp_nat));
        chk(pend_tag, "rx_jflags (R10)", int'(rx_jflags), int'(exp_jf));
    endtask

    task automatic run_frame(input vec_t v, input bit good, input bit out_en,
                             input bit lock_after, input int slen, input string tag);
        logic b;
        int   t;
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < slen; o++) begin
                t = o % 4;
                if (s == 0 && o < 10) begin
                    b = WORD[9-o];
                    if (!good && o == 9) b = ~b;
                end else if (s == 0 && o == 10) begin
                    b = v.alarm;
                end else if (s == 0 && o == 11) begin
                    b = v.nat;
                end else if (s > 0 && o < 4) begin
                    b = v.ctl[t*3 + s - 1];
                end else if (s == 3 && o < 8) begin
                    b = v.jo[t];
                    if (out_en && !v.stuff[t]) exp_q[t].push_back(b);
                end else begin
                    b    = lfsr[0];
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    if ({hist[8:0], b} == WORD) b = ~b;
                    if (out_en) exp_q[t].push_back(b);
                end
                send(b);
                if (s == 0 && o == 0 && pend_valid) begin
                    @(negedge clk);
                    #1;
                    do_check();
                end
            end
        end
        for (int k = 0; k < 4; k++) begin
            pend_cnt[k] = out_en ? (slen - 7 + (v.stuff[k] ? 0 : 1)) : 0;
        end
        pend_locked = lock_after;
        pend_tag    = tag;
        pend_valid  = 1'b1;
        if (out_en) begin
            exp_alarm = v.alarm;
            exp_nat   = v.nat;
            exp_jf    = v.jo;
        end
    endtask

    task automatic flush();
        send(1'b0);
        @(negedge clk);
        #1;
        if (pend_valid) do_check();
        pend_valid = 1'b0;
    endtask

    task automatic do_reset(input logic m);
        @(posedge clk);
        #2;
        rst_n = 1'b0;
        mode  = m;
        din   = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R12", "locked in reset", int'(locked), 0);
        chk("R12", "trib_clk in reset", int'(trib_clk), 0);
        chk("R12", "trib_data in reset", int'(trib_data), 0);
        chk("R12", "rx_alarm in reset", int'(rx_alarm), 0);
        chk("R12", "rx_national in reset", int'(rx_national), 0);
        chk("R12", "rx_jflags in reset", int'(rx_jflags), 0);
        for (int t = 0; t < 4; t++) begin
            exp_q[t].delete();
            pulse_cnt[t] = 0;
        end
        data_err  = 0;
        exp_alarm = 1'b0;
        exp_nat   = 1'b0;
        exp_jf    = '0;
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        repeat (40) send(1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete (all requirements)");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // short format: acquisition over three frames (R1, R4)
        do_reset(1'b0);
        run_frame(VECS[0], 1'b1, 1'b0, 1'b0, S_LO, "R1 R4 first sighting");
        run_frame(VECS[1], 1'b1, 1'b0, 1'b0, S_LO, "R1 R4 second sighting");
        run_frame(VECS[2], 1'b1, 1'b1, 1'b1, S_LO, "R1 R8 lock frame");

        // stuffing and status vectors (R5, R6, R7, R8, R9, R10)
        for (int i = 0; i < NVEC; i++) begin
            run_frame(VECS[i], 1'b1, 1'b1, 1'b1, S_LO,
                      $sformatf("R5 R6 R7 R8 vector %0d", i));
        end

        // loss of lock: three misses tolerated, fourth drops lock (R2)
        run_frame(VSAFE, 1'b0, 1'b1, 1'b1, S_LO, "R2 miss 1");
        run_frame(VSAFE, 1'b0, 1'b1, 1'b1, S_LO, "R2 miss 2");
        run_frame(VSAFE, 1'b0, 1'b1, 1'b1, S_LO, "R2 miss 3");
        run_frame(VSAFE, 1'b0, 1'b0, 1'b0, S_LO, "R2 miss 4");

        // confirmation broken by a bad word, then full reacquisition (R3, R1)
        run_frame(VSAFE, 1'b1, 1'b0, 1'b0, S_LO, "R3 sighting");
        run_frame(VSAFE, 1'b0, 1'b0, 1'b0, S_LO, "R3 broken confirm");
        run_frame(VSAFE, 1'b1, 1'b0, 1'b0, S_LO, "R3 new sighting");
        run_frame(VSAFE, 1'b1, 1'b0, 1'b0, S_LO, "R3 second sighting");
        run_frame(VECS[3], 1'b1, 1'b1, 1'b1, S_LO, "R1 R3 relock");
        flush();

        // long format (R11)
        do_reset(1'b1);
        run_frame(VECS[4], 1'b1, 1'b0, 1'b0, S_HI, "R11 R4 sighting");
        run_frame(VECS[4], 1'b1, 1'b0, 1'b0, S_HI, "R11 R4 second sighting");
        run_frame(VECS[2], 1'b1, 1'b1, 1'b1, S_HI, "R11 lock frame");
        run_frame(VECS[3], 1'b1, 1'b1, 1'b1, S_HI, "R11 R6 locked frame");
        flush();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule